// File: doc/BRIEF.md
# Critical-conduction switching cycle sequencer

This block is the digital heart of a boost power-factor stage that runs at the boundary between continuous and discontinuous conduction. It takes digitised comparator results (demagnetization sense above a high threshold, demagnetization sense above a low threshold, on-time ramp past the control level, ramp past its ceiling, and switch current past its limit) together with a supervisor enable and a fault flag. From them it produces one gate-drive request, a one-cycle strobe marking each turn-on and a ramp-discharge request.

A switching period begins when the demagnetization detector has been armed by the sense signal rising above the high threshold and then fires when the signal drops below the low threshold. If no such event arrives within a restart period of off-time, a watchdog forces the next turn-on. The on-time ends on a ramp trip, a ramp-ceiling trip, or a current-limit trip; the current-limit trip is masked for a blanking window after each turn-on. Stop requests win over start requests. All five comparator inputs pass through two-flop synchronizers; blanking and restart periods are counted in clock cycles derived from parameters giving the clock frequency in MHz, the blanking time in ns and the restart time in µs.

The controller has three states. IDLE (drive off, watchdog halted, detector disarmed) is left for OFF when enabled and fault free. OFF (drive off, ramp discharged, watchdog counting) goes to ON on a start request with no stop request, or back to IDLE on fault or disable. ON (drive on, blanking counter running) goes to OFF on a stop request, or to IDLE on fault or disable.

Top module: `crm_cycle_seq`

## Requirements
- R1: During and right after reset the gate request is low, the ramp-discharge request is high and the cycle-start strobe is low.
- R2: With the sense input first above the high threshold (hi=1, lo=1) and then below the low threshold (hi=0, lo=0), the gate request rises on the third rising clock edge after the falling change is applied.
- R3: A fall below the low threshold that was not preceded by a rise above the high threshold in the same off-time starts no on-time.
- R4: A ramp trip ends the on-time, also inside the blanking window; the gate request falls on the third rising edge after the trip is applied.
- R5: A ramp-ceiling trip ends the on-time with the same three-edge latency as the ramp trip.
- R6: A current-limit trip is ignored during the first BLANK_CYC = BLANK_NS*CLK_MHZ/1000 on-cycles; with the trip held from before turn-on the gate stays high for exactly BLANK_CYC+1 cycles.
- R7: A current-limit trip applied after the blanking window ends the on-time on the third rising edge after it is applied.
- R8: After WD_CYC = RESTART_US*CLK_MHZ off cycles without a demagnetization event a new on-time is forced; from enable rising in IDLE, the gate rises on edge WD_CYC+1.
- R9: While the enable is low or a fault is present the watchdog is halted and no on-time starts; when the condition clears the watchdog restarts from zero, so the gate rises on edge WD_CYC+1.
- R10: A start request coinciding with a ramp or ramp-ceiling trip leaves the drive off; once the trip clears, a pending watchdog start turns the drive on at the third edge.
- R11: A fault or loss of enable drops the gate request in the same cycle and clears the armed state of the demagnetization detector.
- R12: The cycle-start strobe is high for exactly the first cycle of each on-time, and the ramp-discharge request is high whenever the gate request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Supervisor enable, synchronous to clk |
| fault_i | input | 1 | Combined fault flag (overvoltage, undervoltage, shutdown), synchronous |
| zcd_hi_i | input | 1 | Demagnetization sense above high threshold (asynchronous) |
| zcd_lo_i | input | 1 | Demagnetization sense above low threshold (asynchronous) |
| ramp_trip_i | input | 1 | On-time ramp above control level (asynchronous) |
| ramp_ceil_i | input | 1 | On-time ramp above its ceiling (asynchronous) |
| ocp_trip_i | input | 1 | Switch current above limit (asynchronous) |
| gate_drive_o | output | 1 | Gate-drive request |
| cycle_start_o | output | 1 | One-cycle strobe at each turn-on |
| ramp_discharge_o | output | 1 | Ramp-discharge request, high during off-time |

## Verification
The start path is driven with a proper arm-then-fall sequence, with a fall lacking the arm, with an arm erased by a brief fault, and with no event at all so that only the watchdog can start; these separate event starts from forced starts and show that arming order and arm clearing matter. The stop path is driven by a ramp trip inside the blanking window, a ceiling trip, a current-limit trip held across the window and one applied after it, which tells masked from unmasked current-limit handling and checks each stop latency. A start coinciding with a held ramp trip, and long fault and disable intervals measured against the restart period, separate reset dominance and watchdog halting from normal restart timing.

// File: rtl/crm_seq_pkg.sv
package crm_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OFF  = 2'd1,
        ST_ON   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= 1'b0;
                    stab_q <= 1'b0;
                end else begin
                    meta_q <= async_i[g];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[g] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/crm_interval_timer.sv
module crm_interval_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic reached
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q == LIM);

    // R8: once the limit is reached the count saturates until cleared
    assert_timer_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !clear) |=> reached);

    // R6: a cleared timer never reports the limit on the next cycle (LIMIT >= 1)
    assert_timer_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/crm_demag_detect.sv
module crm_demag_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic above_hi,
    input  logic above_lo,
    output logic fire
);
    logic armed_q;

    assign fire = enable && armed_q && !above_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (!enable || fire) begin
            armed_q <= 1'b0;
        end else if (above_hi) begin
            armed_q <= 1'b1;
        end
    end

    // R3: the detector arms only after the high threshold was seen
    assert_arm_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(above_hi));

    // R11: a disabled detector is disarmed on the next cycle
    assert_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !armed_q);
endmodule

// File: rtl/crm_cycle_seq.sv
module crm_cycle_seq
    import crm_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int BLANK_NS   = 256,
    parameter int RESTART_US = 180
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic fault_i,
    input  logic zcd_hi_i,
    input  logic zcd_lo_i,
    input  logic ramp_trip_i,
    input  logic ramp_ceil_i,
    input  logic ocp_trip_i,
    output logic gate_drive_o,
    output logic cycle_start_o,
    output logic ramp_discharge_o
);
    localparam int BLANK_RAW = (BLANK_NS * CLK_MHZ) / 1000;
    localparam int BLANK_CYC = (BLANK_RAW < 1) ? 1 : BLANK_RAW;
    localparam int WD_RAW    = RESTART_US * CLK_MHZ;
    localparam int WD_CYC    = (WD_RAW < 2) ? 2 : WD_RAW;

    localparam int IX_HI   = 0;
    localparam int IX_LO   = 1;
    localparam int IX_RAMP = 2;
    localparam int IX_CEIL = 3;
    localparam int IX_OCP  = 4;
    localparam int NSYNC   = 5;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;

    assign raw_in[IX_HI]   = zcd_hi_i;
    assign raw_in[IX_LO]   = zcd_lo_i;
    assign raw_in[IX_RAMP] = ramp_trip_i;
    assign raw_in[IX_CEIL] = ramp_ceil_i;
    assign raw_in[IX_OCP]  = ocp_trip_i;

    crm_sync #(.WIDTH(NSYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    seq_state_t state_q, state_d;
    logic       start_q;
    logic       run_ok;
    logic       dm_fire;
    logic       blank_done;
    logic       wd_done;
    logic       stop_req;
    logic       start_req;

    assign run_ok = enable_i && !fault_i;

    crm_demag_detect u_demag (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   ((state_q == ST_OFF) && run_ok),
        .above_hi (syn[IX_HI]),
        .above_lo (syn[IX_LO]),
        .fire     (dm_fire)
    );

    crm_interval_timer #(.LIMIT(BLANK_CYC)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_ON),
        .run     (1'b1),
        .reached (blank_done)
    );

    crm_interval_timer #(.LIMIT(WD_CYC - 1)) u_watchdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_OFF),
        .run     (1'b1),
        .reached (wd_done)
    );

    assign stop_req  = syn[IX_RAMP] || syn[IX_CEIL] || (syn[IX_OCP] && blank_done);
    assign start_req = dm_fire || wd_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_ok) state_d = ST_OFF;
            ST_OFF: begin
                if (!run_ok)                     state_d = ST_IDLE;
                else if (start_req && !stop_req) state_d = ST_ON;
            end
            ST_ON: begin
                if (!run_ok)       state_d = ST_IDLE;
                else if (stop_req) state_d = ST_OFF;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_d == ST_ON) && (state_q != ST_ON);
        end
    end

    always_comb begin
        gate_drive_o     = (state_q == ST_ON) && run_ok;
        ramp_discharge_o = !((state_q == ST_ON) && run_ok);
        cycle_start_o    = start_q;
    end

    // R12: the start strobe lasts one cycle
    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o);

    // R12: every rise of the drive coincides with the start strobe
    assert_strobe_on_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_drive_o) |-> cycle_start_o);

    // R6: current limit inside the blanking window does not end the on-time
    assert_blank_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && run_ok && !blank_done && !syn[IX_RAMP] && !syn[IX_CEIL])
        |=> (state_q == ST_ON));

    // R10: a ramp or ceiling trip in the off state blocks any start
    assert_reset_dominant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && (syn[IX_RAMP] || syn[IX_CEIL])) |=> (state_q != ST_ON));

    // R8: a start without a demagnetization event needs an expired watchdog
    assert_forced_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && $past(state_q) == ST_OFF && !$past(dm_fire)) |-> $past(wd_done));

    // R9 R11: fault or disable sends the controller to idle
    assert_fault_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> (state_q == ST_IDLE));
endmodule

// File: tb/sim_crm_cycle_seq.sv
`timescale 1ns/1ps
module sim_crm_cycle_seq;
    localparam int CLK_MHZ    = 100;
    localparam int BLANK_NS   = 100;
    localparam int RESTART_US = 5;
    localparam int BLK = BLANK_NS * CLK_MHZ / 1000;
    localparam int WD  = RESTART_US * CLK_MHZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0, fault_i = 1'b0;
    logic zcd_hi_i = 1'b0, zcd_lo_i = 1'b0;
    logic ramp_trip_i = 1'b0, ramp_ceil_i = 1'b0, ocp_trip_i = 1'b0;
    logic gate_drive_o, cycle_start_o, ramp_discharge_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    crm_cycle_seq #(.CLK_MHZ(CLK_MHZ), .BLANK_NS(BLANK_NS), .RESTART_US(RESTART_US)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .fault_i(fault_i),
        .zcd_hi_i(zcd_hi_i), .zcd_lo_i(zcd_lo_i), .ramp_trip_i(ramp_trip_i),
        .ramp_ceil_i(ramp_ceil_i), .ocp_trip_i(ocp_trip_i),
        .gate_drive_o(gate_drive_o), .cycle_start_o(cycle_start_o),
        .ramp_discharge_o(ramp_discharge_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // negedge samples until the drive reaches level lvl; -1 if not within lim
    task automatic count_to(input bit lvl, input int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (gate_drive_o == lvl) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic go_off();
        int n;
        ramp_trip_i = 1'b1;
        count_to(1'b0, 10, n);
        ramp_trip_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic demag_pulse();
        zcd_hi_i = 1'b1; zcd_lo_i = 1'b1;
        wait_neg(4);
        zcd_hi_i = 1'b0; zcd_lo_i = 1'b0;
    endtask

    task automatic t_reset();
        wait_neg(2);
        check(gate_drive_o == 1'b0, "R1 gate in reset", gate_drive_o, 0);
        check(ramp_discharge_o == 1'b1, "R1 discharge in reset", ramp_discharge_o, 1);
        check(cycle_start_o == 1'b0, "R1 strobe in reset", cycle_start_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gate_drive_o == 1'b0, "R1 gate after reset", gate_drive_o, 0);
    endtask

    task automatic t_disabled();
        int n;
        count_to(1'b1, WD + 100, n);
        check(n == -1, "R9 disabled no start", n, -1);
    endtask

    task automatic t_wd_startup();
        int n;
        enable_i = 1'b1;
        count_to(1'b1, WD + 50, n);
        check(n == WD + 1, "R8 watchdog start edge", n, WD + 1);
        check(cycle_start_o == 1'b1, "R12 strobe at turn-on", cycle_start_o, 1);
        check(ramp_discharge_o == 1'b0, "R12 discharge off in on-time", ramp_discharge_o, 0);
        @(negedge clk);
        check(cycle_start_o == 1'b0, "R12 strobe one cycle", cycle_start_o, 0);
        ramp_trip_i = 1'b1;
        count_to(1'b0, 10, n);
        check(n == 3, "R4 ramp stop latency", n, 3);
        check(ramp_discharge_o == 1'b1, "R12 discharge in off-time", ramp_discharge_o, 1);
        ramp_trip_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic t_demag();
        int n;
        demag_pulse();
        count_to(1'b1, 20, n);
        check(n == 3, "R2 demag start latency", n, 3);
        ramp_trip_i = 1'b1;
        count_to(1'b0, 10, n);
        check(n == 3, "R4 ramp stop inside blanking", n, 3);
        ramp_trip_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic t_order();
        int n;
        zcd_lo_i = 1'b1;
        wait_neg(4);
        zcd_lo_i = 1'b0;
        count_to(1'b1, 30, n);
        check(n == -1, "R3 fall without arm ignored", n, -1);
    endtask

    task automatic t_blank();
        int n;
        ocp_trip_i = 1'b1;
        wait_neg(4);
        demag_pulse();
        count_to(1'b1, 20, n);
        check(n == 3, "R6 start with limit held", n, 3);
        n = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (gate_drive_o) n++;
            else break;
        end
        check(n == BLK + 1, "R6 blanking on-time length", n, BLK + 1);
        ocp_trip_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic t_ocp_late();
        int n;
        demag_pulse();
        count_to(1'b1, 20, n);
        wait_neg(BLK + 5);
        check(gate_drive_o == 1'b1, "R7 still on before trip", gate_drive_o, 1);
        ocp_trip_i = 1'b1;
        count_to(1'b0, 10, n);
        check(n == 3, "R7 limit stop latency", n, 3);
        ocp_trip_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic t_ceil();
        int n;
        demag_pulse();
        count_to(1'b1, 20, n);
        ramp_ceil_i = 1'b1;
        count_to(1'b0, 10, n);
        check(n == 3, "R5 ceiling stop latency", n, 3);
        ramp_ceil_i = 1'b0;
        wait_neg(4);
    endtask

    task automatic t_dominant();
        int n;
        ramp_trip_i = 1'b1;
        wait_neg(4);
        demag_pulse();
        count_to(1'b1, WD + 50, n);
        check(n == -1, "R10 start blocked by trip", n, -1);
        ramp_trip_i = 1'b0;
        count_to(1'b1, 10, n);
        check(n == 3, "R10 pending start after trip", n, 3);
        go_off();
    endtask

    task automatic t_fault_drop();
        int n;
        demag_pulse();
        count_to(1'b1, 20, n);
        fault_i = 1'b1;
        #1;
        check(gate_drive_o == 1'b0, "R11 gate drops same cycle", gate_drive_o, 0);
        check(ramp_discharge_o == 1'b1, "R12 discharge on fault", ramp_discharge_o, 1);
        count_to(1'b1, WD + 100, n);
        check(n == -1, "R9 watchdog halted in fault", n, -1);
        fault_i = 1'b0;
        count_to(1'b1, WD + 50, n);
        check(n == WD + 1, "R9 watchdog restart after fault", n, WD + 1);
        go_off();
    endtask

    task automatic t_fault_arm();
        int n;
        zcd_hi_i = 1'b1; zcd_lo_i = 1'b1;
        wait_neg(4);
        zcd_hi_i = 1'b0;
        wait_neg(4);
        fault_i = 1'b1;
        wait_neg(2);
        fault_i = 1'b0;
        wait_neg(4);
        zcd_lo_i = 1'b0;
        count_to(1'b1, 30, n);
        check(n == -1, "R11 arm cleared by fault", n, -1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_wd_startup();
        t_demag();
        t_order();
        t_blank();
        t_ocp_late();
        t_ceil();
        t_dominant();
        t_fault_drop();
        t_fault_arm();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule